// File: doc/BRIEF.md
# Display Memory Auto-Increment Addresser

This block forms the display-memory address for a character window laid out as 26 rows. A host bus reaches three registers: a row register, a column register and a data port. Loading the row and column registers places a cursor. Each read or write through the data port issues one memory strobe at the cursor and then moves the cursor one cell on. Software can therefore fill or dump a whole screen with a run of data-port accesses and no address arithmetic of its own.

The cursor-to-address mapping is not linear. The first 32 columns of every row are packed at 32 bytes per row. Columns 32 to 39 of rows 0 to 24 are packed 8 per row into a separate region that starts at offset 338h, above the main area. Row 25 holds only 24 cells. After its last cell the cursor returns to the origin. The resulting 10-bit offset is placed inside one of several 1 KiB memory blocks, chosen by a block index input, to give a 16-bit address.

Top module: `disp_addr_gen`

## Requirements
- R1: A synchronous reset sets both the row and the column cursor to 0. Read back through the host registers, they then return 0.
- R2: Register select code 0 is the row register and code 1 is the column register. A host write with that code loads the cursor field from the low bits of the write data. A host read with that code returns the field, zero-extended, on the read data.
- R3: A host read or write with select code 2 (data port) raises the memory strobe in the same cycle. The address is formed from the cursor as it stood before the access. The memory write enable equals the host write, the memory write data equals the host write data, and the host read data equals the memory read data.
- R4: After a data-port access in rows 0 to 24, the column advances by one at the next clock edge. At column 39 the column instead returns to 0 and the row advances by one.
- R5: After a data-port access at row 25, column 23, the row and the column both return to 0.
- R6: For columns 0 to 31 the 10-bit offset is row*32 + column. For example, row 1 column 0 gives 020h, and row 25 column 23 gives 337h.
- R7: For columns 32 to 39 in rows 0 to 24 the offset is 338h + row*8 + (column-32). For example, row 23 column 32 gives 3F0h, and row 24 column 39 gives 3FFh.
- R8: The memory address is the block index times 400h plus the offset, on 16 bits.
- R9: Without a data-port access the strobe stays low. Without a data-port access or a row or column write, the cursor holds. Select code 3 is ignored on writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 2 | Register select: 0 row, 1 column, 2 data port, 3 none |
| bus_wr | input | 1 | Host write request |
| bus_rd | input | 1 | Host read request |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| blk_idx | input | 4 | Index of the 1 KiB memory block |
| mem_stb | output | 1 | Memory access strobe, one cycle per data-port access |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The column wrap and the row advance fall in the same clock edge when a data-port access lands on column 39. That same access must also issue its strobe into the packed region. The bench provokes this by loading the cursor to row 24, column 39. It judges the cycle by the strobed address 3FFh and by reading back row 25, column 0 afterwards. A full sweep of 1024 accesses then crosses every such edge and requires each offset to be hit exactly once, with the cursor back at the origin at the end.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

    typedef enum logic [1:0] {
        SEL_ROW  = 2'd0,
        SEL_COL  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/disp_rc_step.sv
// Next cursor position after one data-port access.
module disp_rc_step #(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int LAST_ROW  = 25,
    parameter int LAST_COL  = 39,
    parameter int TAIL_LAST = 23
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row_nxt,
    output logic [COL_W-1:0] col_nxt
);
    localparam logic [ROW_W-1:0] ROW_END = ROW_W'(LAST_ROW);
    localparam logic [COL_W-1:0] COL_END = COL_W'(LAST_COL);
    localparam logic [COL_W-1:0] TAIL_END = COL_W'(TAIL_LAST);

    always_comb begin
        row_nxt = row;
        col_nxt = col + COL_W'(1);
        if (row == ROW_END && col == TAIL_END) begin
            row_nxt = '0;
            col_nxt = '0;
        end else if (col == COL_END) begin
            col_nxt = '0;
            row_nxt = row + ROW_W'(1);
        end
    end
endmodule

// File: rtl/disp_offset_map.sv
// Cursor to in-block offset: main area for low columns, packed area above it.
module disp_offset_map #(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int OFS_W     = 10,
    parameter int MAIN_COLS = 32,
    parameter int PACK_BASE = 'h338,
    parameter int PACK_COLS = 8
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [OFS_W-1:0] offset
);
    localparam logic [OFS_W-1:0] MAIN_N = OFS_W'(MAIN_COLS);
    localparam logic [OFS_W-1:0] PACK_N = OFS_W'(PACK_COLS);
    localparam logic [OFS_W-1:0] PACK_B = OFS_W'(PACK_BASE);

    logic [OFS_W-1:0] row_x;
    logic [OFS_W-1:0] col_x;
    logic [OFS_W-1:0] main_ofs;
    logic [OFS_W-1:0] pack_ofs;

    always_comb begin
        row_x    = OFS_W'(row);
        col_x    = OFS_W'(col);
        main_ofs = row_x * MAIN_N + col_x;
        pack_ofs = PACK_B + row_x * PACK_N + (col_x - MAIN_N);
        offset   = (col_x < MAIN_N) ? main_ofs : pack_ofs;
    end
endmodule

// File: rtl/disp_base_add.sv
// Places the offset inside the selected memory block.
module disp_base_add #(
    parameter int BLK_W  = 4,
    parameter int OFS_W  = 10,
    parameter int ADDR_W = 16
) (
    input  logic [BLK_W-1:0]  blk_idx,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = ADDR_W'(blk_idx) << OFS_W;
        addr = base + ADDR_W'(offset);
    end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
    import disp_addr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int OFS_W     = 10,
    parameter int BLK_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int LAST_ROW  = 25,
    parameter int LAST_COL  = 39,
    parameter int TAIL_LAST = 23,
    parameter int MAIN_COLS = 32,
    parameter int PACK_BASE = 'h338,
    parameter int PACK_COLS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BLK_W-1:0]  blk_idx,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } cursor_t;

    cursor_t          cur_d, cur_q;
    reg_sel_e         sel;
    logic             port_hit;
    logic [ROW_W-1:0] row_step;
    logic [COL_W-1:0] col_step;
    logic [OFS_W-1:0] offset;
    logic [ROW_W-1:0] row_cur;
    logic [COL_W-1:0] col_cur;

    assign sel      = reg_sel_e'(bus_sel);
    assign port_hit = (sel == SEL_DATA) && (bus_wr || bus_rd);
    assign row_cur  = cur_q.row;
    assign col_cur  = cur_q.col;

    disp_rc_step #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LAST_ROW(LAST_ROW),
        .LAST_COL(LAST_COL), .TAIL_LAST(TAIL_LAST)
    ) u_step (
        .row(cur_q.row), .col(cur_q.col),
        .row_nxt(row_step), .col_nxt(col_step)
    );

    disp_offset_map #(
        .ROW_W(ROW_W), .COL_W(COL_W), .OFS_W(OFS_W),
        .MAIN_COLS(MAIN_COLS), .PACK_BASE(PACK_BASE), .PACK_COLS(PACK_COLS)
    ) u_map (
        .row(cur_q.row), .col(cur_q.col), .offset(offset)
    );

    disp_base_add #(
        .BLK_W(BLK_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)
    ) u_base (
        .blk_idx(blk_idx), .offset(offset), .addr(mem_addr)
    );

    always_comb begin
        cur_d = cur_q;
        if (bus_wr && sel == SEL_ROW) begin
            cur_d.row = bus_wdata[ROW_W-1:0];
        end else if (bus_wr && sel == SEL_COL) begin
            cur_d.col = bus_wdata[COL_W-1:0];
        end else if (port_hit) begin
            cur_d.row = row_step;
            cur_d.col = col_step;
        end

        mem_stb   = port_hit;
        mem_we    = port_hit && bus_wr;
        mem_wdata = bus_wdata;

        unique case (sel)
            SEL_ROW:  bus_rdata = DATA_W'(cur_q.row);
            SEL_COL:  bus_rdata = DATA_W'(cur_q.col);
            SEL_DATA: bus_rdata = mem_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end
endmodule

// File: rtl/disp_addr_chk.sv
module disp_addr_chk #(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int BLK_W  = 4,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BLK_W-1:0]  blk_idx,
    input logic              mem_stb,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col
);
    logic [ADDR_W-1:0] rel;
    logic              reg_load;

    assign rel      = mem_addr - (ADDR_W'(blk_idx) << OFS_W);
    assign reg_load = bus_wr && (bus_sel == 2'd0 || bus_sel == 2'd1);

    p_we_r3: assert property (@(posedge clk) disable iff (rst)
        mem_stb |-> (mem_we == bus_wr));

    p_col_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && row < ROW_W'(25) && col < COL_W'(39))
        |=> (col == $past(col) + COL_W'(1)) && (row == $past(row)));

    p_col_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && row < ROW_W'(25) && col == COL_W'(39))
        |=> (col == '0) && (row == $past(row) + ROW_W'(1)));

    p_origin_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && row == ROW_W'(25) && col == COL_W'(23))
        |=> (row == '0) && (col == '0));

    p_main_map_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && col < COL_W'(32))
        |-> rel == (ADDR_W'(row) * ADDR_W'(32) + ADDR_W'(col)));

    p_pack_map_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && col >= COL_W'(32) && row < ROW_W'(25))
        |-> rel == (ADDR_W'('h338) + ADDR_W'(row) * ADDR_W'(8) + ADDR_W'(col) - ADDR_W'(32)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!mem_stb && !reg_load) |=> ($stable(row) && $stable(col)));

    p_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel != 2'd2) |-> !mem_stb);
endmodule

bind disp_addr_gen disp_addr_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .blk_idx(blk_idx), .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
    .row(row_cur), .col(col_cur)
);

// File: tb/sim_disp_addr_gen.sv
module sim_disp_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_sel = 2'd3;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  blk_idx = '0;
    logic        mem_stb;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        got_stb, got_we;
    logic [15:0] got_addr;
    logic [7:0]  got_rdata, got_wdata;

    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_addr_gen u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_idx(blk_idx),
        .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int exp_ofs(int r, int c);
        if (c < 32) return r * 32 + c;
        return 'h338 + r * 8 + (c - 32);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at a falling edge, sample, commit at the rising edge.
    task automatic bus_cycle(logic [1:0] sel, logic wr, logic rd, logic [7:0] wd);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        #1;
        got_stb = mem_stb; got_we = mem_we; got_addr = mem_addr;
        got_rdata = bus_rdata; got_wdata = mem_wdata;
        @(posedge clk);
        #1;
        bus_sel = 2'd3; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic read_cursor(output int r, output int c);
        bus_cycle(2'd0, 1'b0, 1'b1, 8'h00); r = int'(got_rdata);
        bus_cycle(2'd1, 1'b0, 1'b1, 8'h00); c = int'(got_rdata);
    endtask

    task automatic place(int r, int c);
        bus_cycle(2'd0, 1'b1, 1'b0, 8'(r));
        bus_cycle(2'd1, 1'b1, 1'b0, 8'(c));
    endtask

    task automatic t_reset();
        int r, c;
        read_cursor(r, c);
        chk("R1 row after reset", r, 0);
        chk("R1 col after reset", c, 0);
    endtask

    task automatic t_regs();
        int r, c;
        place(7, 12);
        read_cursor(r, c);
        chk("R2 row readback", r, 7);
        chk("R2 col readback", c, 12);
        bus_cycle(2'd3, 1'b1, 1'b0, 8'h3F);
        chk("R9 strobe on code 3", int'(got_stb), 0);
        bus_cycle(2'd3, 1'b0, 1'b1, 8'h00);
        chk("R9 code 3 reads 0", int'(got_rdata), 0);
        read_cursor(r, c);
        chk("R9 row kept", r, 7);
        chk("R9 col kept", c, 12);
    endtask

    task automatic t_linear();
        int r, c;
        blk_idx = 4'd3;
        place(1, 0);
        bus_cycle(2'd2, 1'b1, 1'b0, 8'hA7);
        chk("R3 strobe on write", int'(got_stb), 1);
        chk("R3 write enable", int'(got_we), 1);
        chk("R3 write data", int'(got_wdata), 'hA7);
        chk("R6 R8 address row1 col0", int'(got_addr), 3 * 'h400 + 'h020);
        read_cursor(r, c);
        chk("R4 col advanced", c, 1);
        chk("R4 row kept", r, 1);
    endtask

    task automatic t_packed();
        int r, c;
        blk_idx = 4'd9;
        place(23, 32);
        bus_cycle(2'd2, 1'b0, 1'b1, 8'h00);
        chk("R3 read enable low", int'(got_we), 0);
        chk("R7 R8 address row23 col32", int'(got_addr), 9 * 'h400 + 'h3F0);
        chk("R3 read data", int'(got_rdata), int'(8'(('h3F0 & 'hFF) ^ 'h5A)));
        // column wrap and row carry in the same access
        place(24, 39);
        bus_cycle(2'd2, 1'b0, 1'b1, 8'h00);
        chk("R7 address row24 col39", int'(got_addr), 9 * 'h400 + 'h3FF);
        read_cursor(r, c);
        chk("R4 wrap row", r, 25);
        chk("R4 wrap col", c, 0);
    endtask

    task automatic t_end();
        int r, c;
        blk_idx = 4'd0;
        place(25, 23);
        bus_cycle(2'd2, 1'b1, 1'b0, 8'h20);
        chk("R6 address row25 col23", int'(got_addr), 'h337);
        read_cursor(r, c);
        chk("R5 row to origin", r, 0);
        chk("R5 col to origin", c, 0);
    endtask

    task automatic t_sweep();
        bit seen [1024];
        int r, c, bad, dup;
        blk_idx = 4'd5;
        place(0, 0);
        r = 0; c = 0; bad = 0; dup = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        for (int n = 0; n < 1024; n++) begin
            bus_cycle(2'd2, 1'b1, 1'b0, 8'(n));
            if (int'(got_addr) != 5 * 'h400 + exp_ofs(r, c)) bad++;
            if (got_addr[15:10] == 6'd5) begin
                if (seen[got_addr[9:0]]) dup++;
                seen[got_addr[9:0]] = 1'b1;
            end
            if (r == 25 && c == 23) begin r = 0; c = 0; end
            else if (c == 39) begin c = 0; r++; end
            else c++;
        end
        chk("R6 R7 sweep addresses", bad, 0);
        chk("R6 R7 sweep duplicates", dup, 0);
        read_cursor(r, c);
        chk("R5 sweep ends at row 0", r, 0);
        chk("R5 sweep ends at col 0", c, 0);
    endtask

    task automatic t_idle();
        int r, c;
        place(10, 5);
        repeat (4) begin
            bus_cycle(2'd2, 1'b0, 1'b0, 8'hFF);
            chk("R9 no strobe when idle", int'(got_stb), 0);
        end
        read_cursor(r, c);
        chk("R9 idle row", r, 10);
        chk("R9 idle col", c, 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_linear();
        t_packed();
        t_end();
        t_sweep();
        t_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule